// File: doc/BRIEF.md
# Cycle-Exact Component Sequencer

This block is the control core of one processing component in a machine built from several identical components that share one broadcast bus and one clock. It walks through a small program held in a local instruction store, one instruction per address. Every instruction occupies a fixed number of clock cycles that a compiler can know in advance. Because of this, several copies started on the same edge can meet on the bus at planned cycles without any handshake between them.

The instruction set is deliberately tiny. It can put a register onto the bus, take the bus word into a register, wait for a fixed count, make simple register moves and take a conditional jump. A variant of the receive instruction waits until the next transmission arrives, for fragments whose timing is not padded exactly. A cycle counter output lets a bench line up one copy's transmissions against another copy's receptions.

Instruction word (16 bits): opcode in bits 15:12, destination register in bits 11:10, source register in bits 9:8, immediate in bits 7:0. There are four data registers.

Top module: `comp_sequencer`

## Requirements
- R1: After reset the block is idle: busy, done and bus_drive are low, cycle_count is 0, imem_addr is 0 and all registers hold 0.
- R2: A start pulse while idle or halted begins execution at address 0 with cycle_count 0 on the next cycle; registers keep their values across a restart.
- R3: SEND (opcode 3) lasts one cycle, during which bus_drive is high and bus_out carries register rs; in every other cycle bus_drive is low and bus_out is 0.
- R4: RECV (opcode 4) lasts one cycle and loads register rd with bus_in sampled in that cycle, whether or not bus_valid is high.
- R5: RECW (opcode 5) holds at its address until a cycle with bus_valid high, loads rd with bus_in in that cycle and then advances.
- R6: DELAY (opcode 6) lasts exactly imm cycles, with an immediate of 0 lasting one cycle.
- R7: JNZ (opcode 7) lasts two cycles whether taken or not; it jumps to address imm when register rs is non-zero and otherwise falls through.
- R8: LDI (opcode 1, rd = imm), MOV (opcode 2, rd = rs), DEC (opcode 8, rd = rd - 1) and NOP (opcode 0) each last one cycle; opcodes 10 to 15 behave as NOP.
- R9: HALT (opcode 9) stops execution: done goes high, imem_addr stays at the HALT address, cycle_count stops and the bus is not driven until the next start.
- R10: While running, cycle_count rises by exactly one per cycle, so the value seen during an instruction's first cycle is the number of cycles since start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at address 0 (ignored while running) |
| imem_addr | output | PC_W | Instruction store read address |
| imem_data | input | 16 | Instruction word at imem_addr, combinational read |
| bus_in | input | DW | Word currently on the shared bus |
| bus_valid | input | 1 | Another component transmits this cycle |
| bus_out | output | DW | Word this component places on the bus |
| bus_drive | output | 1 | This component transmits this cycle |
| busy | output | 1 | Program is executing |
| done | output | 1 | Program has reached HALT |
| cycle_count | output | CW | Cycles elapsed since start |

## Verification
The hardest situation to reach is an open-ended receive that idles for several cycles while the bus word changes every cycle, and then has to capture exactly the word of the one cycle in which a transmission is flagged. The bench drives a bus word that changes with each cycle and raises bus_valid in a single chosen slot. A plain receive earlier in the same program shows that sampling ignores bus_valid. The fall-through path of the conditional jump is reached by a countdown loop that runs three passes, so both jump outcomes are timed against hand-computed send slots.

// File: rtl/comp_sequencer.sv
module comp_sequencer #(
  parameter int DW   = 8,
  parameter int PC_W = 6,
  parameter int CW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [PC_W-1:0] imem_addr,
  input  logic [15:0]     imem_data,
  input  logic [DW-1:0]   bus_in,
  input  logic            bus_valid,
  output logic [DW-1:0]   bus_out,
  output logic            bus_drive,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   cycle_count
);
  localparam int NREG  = 4;
  localparam int IMM_W = 8;
  localparam logic [3:0] OP_LDI = 4'd1, OP_MOV = 4'd2, OP_SEND = 4'd3, OP_RECV = 4'd4,
                         OP_RECW = 4'd5, OP_DELAY = 4'd6, OP_JNZ = 4'd7, OP_DEC = 4'd8,
                         OP_HALT = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} state_t;

  state_t            state;
  logic [PC_W-1:0]   pc;
  logic [IMM_W-1:0]  rem, len;
  logic [DW-1:0]     rf [NREG];
  logic [3:0]        op;
  logic [1:0]        rd, rs;
  logic [IMM_W-1:0]  imm;
  logic              run, fixed_last, step_done, taken;

  assign op  = imem_data[15:12];
  assign rd  = imem_data[11:10];
  assign rs  = imem_data[9:8];
  assign imm = imem_data[7:0];

  assign run       = (state == ST_RUN);
  assign busy      = run;
  assign done      = (state == ST_HALT);
  assign imem_addr = pc;
  assign bus_drive = run && (op == OP_SEND);
  assign bus_out   = bus_drive ? rf[rs] : '0;

  always_comb begin
    len = IMM_W'(1);
    if (op == OP_DELAY && imm != '0) len = imm;
    else if (op == OP_JNZ)            len = IMM_W'(2);
  end

  assign fixed_last = (rem == '0) ? (len == IMM_W'(1)) : (rem == IMM_W'(1));
  assign step_done  = (op == OP_RECW) ? bus_valid : fixed_last;
  assign taken      = (op == OP_JNZ) && (rf[rs] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pc          <= '0;
      rem         <= '0;
      cycle_count <= '0;
    end else if (start && state != ST_RUN) begin
      state       <= ST_RUN;
      pc          <= '0;
      rem         <= '0;
      cycle_count <= '0;
    end else if (run) begin
      cycle_count <= cycle_count + CW'(1);
      if (op == OP_HALT) begin
        state <= ST_HALT;
      end else if (step_done) begin
        rem <= '0;
        pc  <= taken ? PC_W'(imm) : pc + PC_W'(1);
      end else begin
        rem <= (rem == '0) ? len - IMM_W'(1) : rem - IMM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (run) begin
      case (op)
        OP_LDI:  rf[rd] <= DW'(imm);
        OP_MOV:  rf[rd] <= rf[rs];
        OP_DEC:  rf[rd] <= rf[rd] - DW'(1);
        OP_RECV: rf[rd] <= bus_in;
        OP_RECW: if (bus_valid) rf[rd] <= bus_in;
        default: ;
      endcase
    end
  end
endmodule

module comp_sequencer_chk #(
  parameter int PC_W = 6,
  parameter int CW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            bus_drive,
  input logic            busy,
  input logic            done,
  input logic [PC_W-1:0] imem_addr,
  input logic [CW-1:0]   cycle_count
);
  // R3
  send_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> busy);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cycle_count == $past(cycle_count) + CW'(1));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(imem_addr) && $stable(cycle_count));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_drive);

  // R2
  start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && imem_addr == '0 && cycle_count == '0);
endmodule

bind comp_sequencer comp_sequencer_chk #(.PC_W(PC_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_drive(bus_drive), .busy(busy),
  .done(done), .imem_addr(imem_addr), .cycle_count(cycle_count)
);

// File: tb/tb_comp_sequencer.sv
module tb_comp_sequencer;
  localparam int DW = 8, PC_W = 6, CW = 16, DEPTH = 1 << PC_W;

  logic clk = 0, rst_n = 0, start = 0, bus_valid = 0;
  logic [DW-1:0] bus_in = '0;
  logic [PC_W-1:0] imem_addr;
  logic [15:0] imem_data;
  logic [DW-1:0] bus_out;
  logic bus_drive, busy, done;
  logic [CW-1:0] cycle_count;
  logic [15:0] mem [DEPTH];

  int n_chk = 0, n_err = 0, wd = 0, valid_slot = -1;
  bit fin = 0;

  // reference model state
  int m_state = 0, m_pc = 0, m_rem = 0, m_cyc = 0, m_n = 0;
  logic [DW-1:0] m_r [4];
  logic [15:0] m_w;
  int sq_c[$], sq_d[$], ex_c[$], ex_d[$];

  always #2 clk = ~clk;
  assign imem_data = mem[imem_addr];

  comp_sequencer #(.DW(DW), .PC_W(PC_W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .imem_addr(imem_addr), .imem_data(imem_data),
    .bus_in(bus_in), .bus_valid(bus_valid), .bus_out(bus_out), .bus_drive(bus_drive),
    .busy(busy), .done(done), .cycle_count(cycle_count));

  function automatic logic [15:0] enc(int op, int rd, int rs, int imm);
    return {op[3:0], rd[1:0], rs[1:0], imm[7:0]};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_pc = 0; m_rem = 0; m_cyc = 0;
      for (int i = 0; i < 4; i++) m_r[i] = '0;
    end else if (start && m_state != 1) begin
      m_state = 1; m_pc = 0; m_rem = 0; m_cyc = 0;
    end else if (m_state == 1) begin
      m_w = mem[m_pc];
      m_cyc++;
      case (int'(m_w[15:12]))
        9: m_state = 2;
        6: begin
          m_n = (m_w[7:0] == 0) ? 1 : int'(m_w[7:0]);
          if (m_rem + 1 >= m_n) begin m_rem = 0; m_pc = (m_pc + 1) % DEPTH; end
          else m_rem++;
        end
        7: begin
          if (m_rem == 0) m_rem = 1;
          else begin
            m_rem = 0;
            m_pc = (m_r[m_w[9:8]] != 0) ? int'(m_w[7:0]) % DEPTH : (m_pc + 1) % DEPTH;
          end
        end
        5: if (bus_valid) begin m_r[m_w[11:10]] = bus_in; m_pc = (m_pc + 1) % DEPTH; end
        default: begin
          case (int'(m_w[15:12]))
            1: m_r[m_w[11:10]] = m_w[7:0];
            2: m_r[m_w[11:10]] = m_r[m_w[9:8]];
            4: m_r[m_w[11:10]] = bus_in;
            8: m_r[m_w[11:10]] = m_r[m_w[11:10]] - 1;
            default: ;
          endcase
          m_pc = (m_pc + 1) % DEPTH;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    bus_in    <= 8'hA0 ^ m_cyc[7:0];
    bus_valid <= (m_state == 1) && (m_cyc == valid_slot);
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      logic ed;
      ed = (m_state == 1) && (mem[m_pc][15:12] == 4'd3);
      chk("R10", "cycle_count", int'(cycle_count), m_cyc);
      chk("R9", "done", int'(done), int'(m_state == 2));
      chk("R2", "busy", int'(busy), int'(m_state == 1));
      chk("R7", "imem_addr", int'(imem_addr), m_pc);
      chk("R3", "bus_drive", int'(bus_drive), int'(ed));
      chk("R3", "bus_out", int'(bus_out), ed ? int'(m_r[mem[m_pc][9:8]]) : 0);
      if (bus_drive) begin sq_c.push_back(int'(cycle_count)); sq_d.push_back(int'(bus_out)); end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = enc(9, 0, 0, 0);
  endtask

  task automatic run_prog(int slot);
    valid_slot = slot;
    sq_c.delete(); sq_d.delete();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    for (int i = 0; i < 5; i++) @(negedge clk);
  endtask

  task automatic check_sends(string req);
    chk(req, "send count", sq_c.size(), ex_c.size());
    for (int i = 0; i < ex_c.size() && i < sq_c.size(); i++) begin
      chk(req, "send slot", sq_c[i], ex_c[i]);
      chk(req, "send data", sq_d[i], ex_d[i]);
    end
  endtask

  task automatic load_a();
    clear_mem();
    mem[0] = enc(1, 0, 0, 8'h5A);
    mem[1] = enc(6, 0, 0, 3);
    mem[2] = enc(3, 0, 0, 0);
    mem[3] = enc(6, 0, 0, 0);
    mem[4] = enc(3, 0, 0, 0);
    mem[5] = enc(9, 0, 0, 0);
    ex_c = '{4, 6}; ex_d = '{8'h5A, 8'h5A};
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "bus_drive", int'(bus_drive), 0);
    chk("R1", "cycle_count", int'(cycle_count), 0);
    chk("R1", "imem_addr", int'(imem_addr), 0);
    rst_n = 1;
    @(negedge clk);

    // R6 delay of 3 and delay of 0
    load_a();
    run_prog(-1);
    check_sends("R6");
    chk("R9", "final count", int'(cycle_count), 8);
    chk("R9", "halt addr", int'(imem_addr), 5);

    // R4 plain receive, R5 open receive
    clear_mem();
    mem[0] = enc(4, 1, 0, 0);
    mem[1] = enc(5, 2, 0, 0);
    mem[2] = enc(3, 0, 1, 0);
    mem[3] = enc(3, 0, 2, 0);
    mem[4] = enc(9, 0, 0, 0);
    ex_c = '{6, 7}; ex_d = '{8'hA0, 8'hA5};
    run_prog(5);
    check_sends("R5");
    chk("R4", "final count", int'(cycle_count), 9);

    // R7 jump both ways, R8 moves and unused opcode
    clear_mem();
    mem[0] = enc(1, 0, 0, 3);
    mem[1] = enc(3, 0, 0, 0);
    mem[2] = enc(8, 0, 0, 0);
    mem[3] = enc(7, 0, 0, 1);
    mem[4] = enc(15, 3, 3, 8'hFF);
    mem[5] = enc(1, 1, 0, 8'h77);
    mem[6] = enc(2, 2, 1, 0);
    mem[7] = enc(3, 0, 2, 0);
    mem[8] = enc(9, 0, 0, 0);
    ex_c = '{1, 5, 9, 16}; ex_d = '{3, 2, 1, 8'h77};
    run_prog(-1);
    check_sends("R7");
    chk("R8", "final count", int'(cycle_count), 18);
    chk("R9", "halt addr", int'(imem_addr), 8);
    chk("R9", "done", int'(done), 1);

    // R2 restart from halted
    load_a();
    run_prog(-1);
    check_sends("R2");

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule